// File: doc/BRIEF.md
# Monitoring Refresh Scheduler and Memory Arbiter

This block decides when a bank of diagnostic monitoring registers gets refreshed. It also lets those refreshes share a single backend engine with read and write transactions to non-volatile memory. Software writes a two-bit mode field. The value 00 asks for one refresh. Each of the other three values makes refreshes repeat at a fixed number of seconds. That period is derived from a timebase tick input, and a parameter sets how many ticks make one second.

Only one transaction can own the backend at a time. When a refresh and a memory transaction collide, the one that already holds the backend runs to completion, and the waiting one starts on the cycle after the backend reports done. Each requester has a command status output. It reads busy from the moment its request is accepted, through any wait in the queue, until the backend reports done for its own transaction. It then reads complete.

Memory requests enter through a valid/ready handshake. A request is taken on a cycle where both `mem_req_valid` and `mem_req_ready` are high. Ready stays low while a memory request is queued or running, so the requester must hold its request until it is taken. All other pins are plain level or pulse signals.

Top module: `mon_refresh_arb`

## Requirements
- R1: After reset, `mode_rd` reads 00, both status outputs read idle (00), neither start strobe is high, no refresh is pending and `mem_req_ready` is high. A write to the mode field is visible on `mode_rd` on the next cycle.
- R2: Writing 00 to the mode field requests exactly one refresh. With the backend free, `be_start_mon` pulses for one cycle two clock edges after the write is sampled, and no further refresh follows.
- R3: Mode 01 repeats a refresh every SLOW_SECS seconds (default 60), mode 10 every MID_SECS seconds (default 10) and mode 11 every FAST_SECS seconds (default 1). One second is TICKS_PER_SEC ticks.
- R4: Any mode write restarts the period count. The first periodic refresh is due exactly one full period after the write, and the period from the earlier mode is discarded.
- R5: A refresh requested while a memory transaction runs waits for it. `be_start_mon` pulses on the cycle after the cycle in which `be_done` ends the memory transaction.
- R6: A memory request accepted while a refresh runs waits for it. `be_start_mem` pulses on the cycle after the cycle in which `be_done` ends the refresh.
- R7: When a refresh and a memory request arrive in the same cycle with the backend free, the memory transaction starts first.
- R8: Status encoding: 00 means idle, 01 means command-in-progress, 10 means complete. A status reads 01 while its request is queued or running. It changes to 10 only on `be_done` for that requester's own transaction.
- R9: A refresh request that arrives while a refresh is already queued or running is merged into it, so only one refresh is carried out.
- R10: A memory request is accepted when valid and ready are both high. Ready is low while a memory request is queued or running. `be_mem_write` carries the accepted request's write flag (1 means write) while `be_start_mem` is high.
- R11: The two start strobes are never high together, and no start is issued while the backend is still busy with a transaction that has not reported done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_en | input | 1 | Write strobe for the mode field |
| mode_wr_data | input | 2 | Mode value to write |
| mode_rd | output | 2 | Current mode field |
| time_tick | input | 1 | Timebase tick; TICKS_PER_SEC ticks make one second |
| mem_req_valid | input | 1 | Memory transaction request valid |
| mem_req_ready | output | 1 | Memory request can be accepted |
| mem_req_write | input | 1 | 1 for a write, 0 for a read; sampled on acceptance |
| be_start_mon | output | 1 | One-cycle pulse that starts a monitoring refresh on the backend |
| be_start_mem | output | 1 | One-cycle pulse that starts a memory transaction on the backend |
| be_mem_write | output | 1 | Write flag of the memory transaction being started |
| be_done | input | 1 | Backend has finished its current transaction |
| mon_cmd_status | output | 2 | Refresh command status (00 idle, 01 in progress, 10 complete) |
| mem_cmd_status | output | 2 | Memory command status (00 idle, 01 in progress, 10 complete) |

## Verification
The assertions check several properties on every cycle. The two start strobes are never high together. No start is issued while the backend is still owned. A status in progress holds until a done arrives. Mode writes appear on the readback one cycle later. Ready is low whenever the memory status shows in progress. Only the bench scenarios can show the properties that depend on timing and order. These are the exact refresh period for each mode, the restart of the count on a mode change, the start one cycle after the other requester's done, memory winning a tie, and a duplicate refresh being merged into one.

// File: rtl/mra_pkg.sv
`timescale 1ns/1ps
package mra_pkg;

  typedef enum logic [1:0] {
    CS_IDLE = 2'b00,
    CS_BUSY = 2'b01,
    CS_DONE = 2'b10
  } cmd_stat_e;

  typedef enum logic [1:0] {
    OWN_FREE = 2'b00,
    OWN_MON  = 2'b01,
    OWN_MEM  = 2'b10
  } be_owner_e;

  localparam logic [1:0] MODE_ONCE = 2'b00;

endpackage

// File: rtl/mra_period_timer.sv
`timescale 1ns/1ps
module mra_period_timer #(
  parameter int unsigned TICKS_PER_SEC = 1,
  parameter int unsigned SLOW_SECS     = 60,
  parameter int unsigned MID_SECS      = 10,
  parameter int unsigned FAST_SECS     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] mode_new,
  input  logic [1:0] mode_cur,
  input  logic       tick,
  output logic       due
);
  import mra_pkg::*;

  localparam int unsigned SW = $clog2(SLOW_SECS + 1);

  logic          sec_pulse;
  logic [SW-1:0] secs_left;

  function automatic logic [SW-1:0] reload_of(input logic [1:0] m);
    case (m)
      2'b01:   return SW'(SLOW_SECS);
      2'b10:   return SW'(MID_SECS);
      2'b11:   return SW'(FAST_SECS);
      default: return '0;
    endcase
  endfunction

  generate
    if (TICKS_PER_SEC <= 1) begin : g_direct
      assign sec_pulse = tick;
    end else begin : g_prescale
      localparam int unsigned PW = $clog2(TICKS_PER_SEC);
      localparam logic [PW-1:0] PLAST = PW'(TICKS_PER_SEC - 1);
      logic [PW-1:0] presc;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          presc <= '0;
        end else if (load) begin
          presc <= '0;
        end else if (tick) begin
          presc <= (presc == PLAST) ? '0 : presc + 1'b1;
        end
      end
      assign sec_pulse = tick && (presc == PLAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_left <= '0;
    end else if (load) begin
      secs_left <= reload_of(mode_new);
    end else if (sec_pulse && (mode_cur != MODE_ONCE)) begin
      if (secs_left <= SW'(1)) secs_left <= reload_of(mode_cur);
      else                     secs_left <= secs_left - 1'b1;
    end
  end

  assign due = !load && sec_pulse && (mode_cur != MODE_ONCE) && (secs_left == SW'(1));

endmodule

// File: rtl/mra_arb_core.sv
`timescale 1ns/1ps
module mra_arb_core (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mon_req,
  input  logic                mem_valid,
  input  logic                mem_write,
  input  logic                be_done,
  output logic                mem_ready,
  output logic                start_mon,
  output logic                start_mem,
  output logic                start_write,
  output mra_pkg::cmd_stat_e  mon_stat,
  output mra_pkg::cmd_stat_e  mem_stat
);
  import mra_pkg::*;

  be_owner_e owner_q;
  logic      mon_pend_q;
  logic      mem_pend_q;
  logic      mem_wr_q;

  logic mon_active, mon_take, mem_take;
  logic finishing, free_now, pick_mem, pick_mon;

  always_comb begin
    mon_active = mon_pend_q || (owner_q == OWN_MON);
    mon_take   = mon_req && !mon_active;
    mem_ready  = !mem_pend_q && (owner_q != OWN_MEM);
    mem_take   = mem_valid && mem_ready;
    finishing  = be_done && (owner_q != OWN_FREE);
    free_now   = (owner_q == OWN_FREE) || finishing;
    pick_mem   = free_now && mem_pend_q;
    pick_mon   = free_now && !mem_pend_q && mon_pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q     <= OWN_FREE;
      mon_pend_q  <= 1'b0;
      mem_pend_q  <= 1'b0;
      mem_wr_q    <= 1'b0;
      start_mon   <= 1'b0;
      start_mem   <= 1'b0;
      start_write <= 1'b0;
      mon_stat    <= CS_IDLE;
      mem_stat    <= CS_IDLE;
    end else begin
      start_mon <= pick_mon;
      start_mem <= pick_mem;

      if (pick_mem)       owner_q <= OWN_MEM;
      else if (pick_mon)  owner_q <= OWN_MON;
      else if (finishing) owner_q <= OWN_FREE;

      if (pick_mem)      mem_pend_q <= 1'b0;
      else if (mem_take) mem_pend_q <= 1'b1;

      if (pick_mon)      mon_pend_q <= 1'b0;
      else if (mon_take) mon_pend_q <= 1'b1;

      if (mem_take) mem_wr_q <= mem_write;
      if (pick_mem) start_write <= mem_wr_q;
      else          start_write <= 1'b0;

      if (mon_take)                              mon_stat <= CS_BUSY;
      else if (finishing && owner_q == OWN_MON)  mon_stat <= CS_DONE;

      if (mem_take)                              mem_stat <= CS_BUSY;
      else if (finishing && owner_q == OWN_MEM)  mem_stat <= CS_DONE;
    end
  end

endmodule

// File: rtl/mon_refresh_arb.sv
`timescale 1ns/1ps
module mon_refresh_arb #(
  parameter int unsigned TICKS_PER_SEC = 1,
  parameter int unsigned SLOW_SECS     = 60,
  parameter int unsigned MID_SECS      = 10,
  parameter int unsigned FAST_SECS     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr_en,
  input  logic [1:0] mode_wr_data,
  output logic [1:0] mode_rd,
  input  logic       time_tick,
  input  logic       mem_req_valid,
  output logic       mem_req_ready,
  input  logic       mem_req_write,
  output logic       be_start_mon,
  output logic       be_start_mem,
  output logic       be_mem_write,
  input  logic       be_done,
  output logic [1:0] mon_cmd_status,
  output logic [1:0] mem_cmd_status
);
  import mra_pkg::*;

  logic [1:0] mode_q;
  logic       period_due;
  logic       refresh_req;
  cmd_stat_e  mon_stat, mem_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= MODE_ONCE;
    else if (mode_wr_en) mode_q <= mode_wr_data;
  end

  mra_period_timer #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .SLOW_SECS     (SLOW_SECS),
    .MID_SECS      (MID_SECS),
    .FAST_SECS     (FAST_SECS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (mode_wr_en),
    .mode_new (mode_wr_data),
    .mode_cur (mode_q),
    .tick     (time_tick),
    .due      (period_due)
  );

  assign refresh_req = (mode_wr_en && (mode_wr_data == MODE_ONCE)) || period_due;

  mra_arb_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .mon_req     (refresh_req),
    .mem_valid   (mem_req_valid),
    .mem_write   (mem_req_write),
    .be_done     (be_done),
    .mem_ready   (mem_req_ready),
    .start_mon   (be_start_mon),
    .start_mem   (be_start_mem),
    .start_write (be_mem_write),
    .mon_stat    (mon_stat),
    .mem_stat    (mem_stat)
  );

  assign mode_rd        = mode_q;
  assign mon_cmd_status = mon_stat;
  assign mem_cmd_status = mem_stat;

endmodule

// File: rtl/mra_chk.sv
`timescale 1ns/1ps
module mra_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_wr_en,
  input logic [1:0] mode_wr_data,
  input logic [1:0] mode_rd,
  input logic       mem_req_valid,
  input logic       mem_req_ready,
  input logic       be_start_mon,
  input logic       be_start_mem,
  input logic       be_done,
  input logic [1:0] mon_cmd_status,
  input logic [1:0] mem_cmd_status
);
  logic own_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           own_q <= 1'b0;
    else if (be_start_mon || be_start_mem) own_q <= !be_done;
    else if (be_done)                     own_q <= 1'b0;
  end

  // R11
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(be_start_mon && be_start_mem));

  // R11
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (be_start_mon || be_start_mem) |-> !own_q);

  // R8
  mon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_cmd_status == 2'b01 && !be_done) |=> (mon_cmd_status == 2'b01));

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_status == 2'b01 && !be_done) |=> (mem_cmd_status == 2'b01));

  // R8
  mon_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_start_mon |-> (mon_cmd_status == 2'b01));

  // R8
  mem_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_start_mem |-> (mem_cmd_status == 2'b01));

  // R10
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_status == 2'b01) |-> !mem_req_ready);

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> (mem_cmd_status == 2'b01));

  // R1
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_en |=> (mode_rd == $past(mode_wr_data)));

endmodule

bind mon_refresh_arb mra_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_wr_en     (mode_wr_en),
  .mode_wr_data   (mode_wr_data),
  .mode_rd        (mode_rd),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .be_start_mon   (be_start_mon),
  .be_start_mem   (be_start_mem),
  .be_done        (be_done),
  .mon_cmd_status (mon_cmd_status),
  .mem_cmd_status (mem_cmd_status)
);

// File: tb/mon_refresh_arb_bench.sv
`timescale 1ns/1ps
module mon_refresh_arb_bench;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr_en = 1'b0;
  logic [1:0] mode_wr_data = 2'b00;
  logic [1:0] mode_rd;
  logic       time_tick = 1'b1;
  logic       mem_req_valid = 1'b0;
  logic       mem_req_ready;
  logic       mem_req_write = 1'b0;
  logic       be_start_mon, be_start_mem, be_mem_write;
  logic       be_done = 1'b0;
  logic [1:0] mon_cmd_status, mem_cmd_status;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  int lat_cfg = 1;
  int bk_busy = 0, bk_left = 0, bk_kind = 0;
  int mon_starts = 0, mem_starts = 0, overlaps = 0;
  int last_mon_start = -1, last_mem_start = -1;
  int last_mon_done = -1, last_mem_done = -1;
  int last_mem_wr = -1;

  always #2 clk = ~clk;

  mon_refresh_arb #(.TICKS_PER_SEC(TPS)) u_mon_refresh_arb (
    .clk(clk), .rst_n(rst_n),
    .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data), .mode_rd(mode_rd),
    .time_tick(time_tick),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .be_start_mon(be_start_mon), .be_start_mem(be_start_mem),
    .be_mem_write(be_mem_write), .be_done(be_done),
    .mon_cmd_status(mon_cmd_status), .mem_cmd_status(mem_cmd_status)
  );

  always @(posedge clk) cyc = cyc + 1;

  // backend model: done comes lat_cfg cycles after a start
  always @(negedge clk) begin
    be_done = 1'b0;
    if (rst_n) begin
      if (be_start_mon || be_start_mem) begin
        if (bk_busy != 0) overlaps = overlaps + 1;
        bk_busy = 1;
        bk_left = lat_cfg;
        bk_kind = be_start_mem ? 2 : 1;
        if (be_start_mon) begin mon_starts++; last_mon_start = cyc; end
        if (be_start_mem) begin mem_starts++; last_mem_start = cyc; last_mem_wr = int'(be_mem_write); end
      end
      if (bk_busy != 0) begin
        if (bk_left == 0) begin
          be_done = 1'b1;
          bk_busy = 0;
          if (bk_kind == 1) last_mon_done = cyc; else last_mem_done = cyc;
        end else begin
          bk_left = bk_left - 1;
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] v);
    mode_wr_en = 1'b1; mode_wr_data = v;
    step(1);
    mode_wr_en = 1'b0;
  endtask

  task automatic wait_mon(input int target);
    int guard = 0;
    while (mon_starts < target && guard < 3000) begin step(1); guard++; end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int k, base, s1, s2, n;
    step(5);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 mode", int'(mode_rd), 0);
    chk("R1 mon status", int'(mon_cmd_status), 0);
    chk("R1 mem status", int'(mem_cmd_status), 0);
    chk("R1 ready", int'(mem_req_ready), 1);
    chk("R1 starts", int'(be_start_mon) + int'(be_start_mem), 0);
    step(20);
    chk("R1 no pending refresh", mon_starts, 0);

    // R2 one-shot refresh
    lat_cfg = 2;
    k = cyc;
    write_mode(2'b00);
    wait_mon(1);
    chk("R2 start cycle", last_mon_start, k + 2);
    step(6);
    chk("R2 status complete", int'(mon_cmd_status), 2);
    step(200);
    chk("R2 single refresh", mon_starts, 1);

    // R3 periodic sweep over the three intervals
    lat_cfg = 1;
    for (int m = 3; m >= 1; m--) begin
      n = (m == 3) ? 1 : (m == 2) ? 10 : 60;
      base = mon_starts;
      k = cyc;
      write_mode(2'(m));
      chk("R1 mode readback", int'(mode_rd), m);
      wait_mon(base + 1);
      chk("R3 first refresh", last_mon_start, k + TPS * n + 2);
      s1 = last_mon_start;
      wait_mon(base + 2);
      chk("R3 interval a", last_mon_start - s1, TPS * n);
      s2 = last_mon_start;
      wait_mon(base + 3);
      chk("R3 interval b", last_mon_start - s2, TPS * n);
    end
    write_mode(2'b00);
    step(10);

    // R4 mode change restarts the count
    base = mon_starts;
    write_mode(2'b10);
    step(15);
    k = cyc;
    write_mode(2'b11);
    chk("R4 nothing from old mode", mon_starts, base);
    wait_mon(base + 1);
    chk("R4 restart", last_mon_start, k + TPS + 2);
    write_mode(2'b00);
    step(10);

    // R5 refresh waits for memory; R9 merge; R10 handshake
    lat_cfg = 6;
    base = mon_starts;
    k = cyc;
    chk("R10 ready idle", int'(mem_req_ready), 1);
    mem_req_valid = 1'b1; mem_req_write = 1'b1;
    step(1);
    mem_req_valid = 1'b0; mem_req_write = 1'b0;
    chk("R10 ready low after accept", int'(mem_req_ready), 0);
    step(1);
    chk("R10 mem start", last_mem_start, k + 2);
    chk("R10 write flag", last_mem_wr, 1);
    write_mode(2'b00);
    write_mode(2'b00);
    chk("R8 refresh queued busy", int'(mon_cmd_status), 1);
    chk("R5 refresh held", mon_starts, base);
    wait_mon(base + 1);
    chk("R5 start after mem done", last_mon_start, last_mem_done + 1);
    chk("R8 mem complete", int'(mem_cmd_status), 2);
    step(30);
    chk("R9 merged refresh", mon_starts, base + 1);
    chk("R8 mon complete", int'(mon_cmd_status), 2);

    // R6 memory waits for refresh
    base = mem_starts;
    write_mode(2'b00);
    step(1);
    mem_req_valid = 1'b1; mem_req_write = 1'b0;
    step(1);
    mem_req_valid = 1'b0;
    chk("R6 mem queued busy", int'(mem_cmd_status), 1);
    chk("R6 mem held", mem_starts, base);
    step(20);
    chk("R6 start after refresh done", last_mem_start, last_mon_done + 1);
    chk("R10 read flag", last_mem_wr, 0);

    // R7 simultaneous arrival
    lat_cfg = 2;
    k = cyc;
    mem_req_valid = 1'b1; mem_req_write = 1'b1;
    mode_wr_en = 1'b1; mode_wr_data = 2'b00;
    step(1);
    mem_req_valid = 1'b0; mode_wr_en = 1'b0;
    step(10);
    chk("R7 memory first", last_mem_start, k + 2);
    chk("R7 refresh next", last_mon_start, last_mem_done + 1);

    // R11 no overlapping starts seen at the backend
    chk("R11 overlaps", overlaps, 0);

    finish_run();
  end

endmodule